// File: doc/BRIEF.md
# Hardware queuing lock unit

This block arbitrates a small set of locks among several processors without letting them spin. Each processor has its own request lane carrying a valid bit, an operation code and a lock number. An acquire on a free lock is granted at once. An acquire on a taken lock puts the requester at the tail of a per-lock waiting line. When the holder releases, ownership passes straight to the oldest waiter, so the other waiters never retry and never race.

Each lock number also owns an atomic fetch-and-increment counter. A processor reads the current count and the unit bumps it by one in the same indivisible step, which suits barrier arrival counting and handing out distinct indices. All results are registered. A grant, an error flag or a returned count appears on a processor's outputs in the cycle after the edge that sampled its request, and lasts one cycle.

Requests from several lanes in one cycle are applied one after another in ascending processor index. A processor may have only one acquire waiting at any time, so a line never needs more entries than there are processors.

Top module: `qlk_unit`

## Requirements
- R1: After reset no grant, error or return-valid output is high, every lock is free and every counter reads zero.
- R2: An acquire (op code 0) on a free lock gives that processor a one-cycle grant, with the lock number on its grant-lock field, in the cycle after the request is sampled.
- R3: An acquire on a lock held by another processor produces no grant and places the requester at the tail of that lock's waiting line.
- R4: A release (op code 1) by the holder while the line is not empty grants the lock in the next cycle to the oldest waiter only, and waiters are served in arrival order.
- R5: Acquires sampled in the same cycle on one lock are applied in ascending processor index: on a free lock the lowest index is granted and the rest queue in ascending order.
- R6: A release by the holder with no waiters makes the lock free, and a later acquire on it is granted in the next cycle.
- R7: A release from a processor that does not hold the lock changes nothing and raises that processor's error output for one cycle; the holder keeps the lock.
- R8: An acquire from a processor that already holds that lock, or that is already waiting on any lock, is dropped and raises its error output for one cycle; at most one grant reaches a processor per cycle.
- R9: A fetch-and-increment (op code 2) returns on the requester's value output, with return-valid high in the next cycle, the counter's value before the step, and the counter advances by one, wrapping from its maximum to zero.
- R10: Several fetch-and-increments sampled in the same cycle on one counter return consecutive values in ascending processor index.
- R11: Locks and counters with different numbers do not affect each other.
- R12: A lock is granted to at most one processor per cycle, and a held lock with queued waiters never becomes free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPROC | One request valid bit per processor |
| req_op | input | 2*NPROC | Op code per processor: 0 acquire, 1 release, 2 fetch-and-increment, 3 no operation |
| req_lock | input | LW*NPROC | Lock or counter number per processor |
| grant | output | NPROC | One-cycle grant pulse per processor |
| grant_lock | output | LW*NPROC | Number of the lock granted, valid with grant |
| err | output | NPROC | One-cycle pulse for a dropped release or acquire |
| ret_valid | output | NPROC | One-cycle pulse marking a fetch-and-increment result |
| ret_val | output | CNT_W*NPROC | Counter value before the increment, valid with ret_valid |

## Verification
The bench builds the unit with four processors, four locks and a four-bit counter. Four processors let one holder sit in front of three queued waiters, so a full line and a chain of handoffs in arrival order can both be seen. The narrow counter brings the wrap from fifteen to zero within sixteen requests, and four locks leave room to show that operations on different numbers in the same cycle stay apart.

// File: rtl/qlk_pkg.sv
package qlk_pkg;

  typedef enum logic [1:0] {
    OP_ACQ = 2'd0,
    OP_REL = 2'd1,
    OP_FAI = 2'd2,
    OP_NOP = 2'd3
  } qlk_op_e;

  // Position in a circular line of the given depth.
  function automatic int unsigned ring_pos(int unsigned base, int unsigned off,
                                           int unsigned depth);
    return (base + off) % depth;
  endfunction

  // Index width for a count of items, never below one bit.
  function automatic int unsigned idx_bits(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/qlk_req_decode.sv
module qlk_req_decode
  import qlk_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NLOCK = 4,
  parameter int LW    = 2
) (
  input  logic [NPROC-1:0]            req_valid,
  input  logic [2*NPROC-1:0]          req_op,
  input  logic [LW*NPROC-1:0]         req_lock,
  output logic [NLOCK-1:0][NPROC-1:0] acq_o,
  output logic [NLOCK-1:0][NPROC-1:0] rel_o,
  output logic [NLOCK-1:0][NPROC-1:0] fai_o
);

  always_comb begin
    acq_o = '0;
    rel_o = '0;
    fai_o = '0;
    for (int p = 0; p < NPROC; p++) begin
      for (int l = 0; l < NLOCK; l++) begin
        if (req_valid[p] && req_lock[LW*p +: LW] == LW'(l)) begin
          acq_o[l][p] = (req_op[2*p +: 2] == OP_ACQ);
          rel_o[l][p] = (req_op[2*p +: 2] == OP_REL);
          fai_o[l][p] = (req_op[2*p +: 2] == OP_FAI);
        end
      end
    end
  end

endmodule

// File: rtl/qlk_lock_slot.sv
module qlk_lock_slot
  import qlk_pkg::*;
#(
  parameter int NPROC = 4,
  localparam int IW = idx_bits(NPROC),
  localparam int CW = $clog2(NPROC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPROC-1:0] acq_i,
  input  logic [NPROC-1:0] rel_i,
  input  logic [NPROC-1:0] busy_i,
  output logic [NPROC-1:0] grant_o,
  output logic [NPROC-1:0] err_o,
  output logic [NPROC-1:0] wait_o,
  output logic             held_o,
  output logic [IW-1:0]    owner_o,
  output logic [CW-1:0]    qcnt_o
);

  logic             held_q, held_n;
  logic [IW-1:0]    owner_q, owner_n;
  logic [IW-1:0]    head_q, head_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [NPROC-1:0] wait_q, wait_n;
  logic [IW-1:0]    line_q [NPROC];
  logic [IW-1:0]    line_n [NPROC];
  logic [NPROC-1:0] gnt_n, err_n;

  // Lanes are applied one after another, lowest index first.
  always_comb begin
    held_n  = held_q;
    owner_n = owner_q;
    head_n  = head_q;
    cnt_n   = cnt_q;
    wait_n  = wait_q;
    line_n  = line_q;
    gnt_n   = '0;
    err_n   = '0;
    for (int p = 0; p < NPROC; p++) begin
      if (acq_i[p]) begin
        if (busy_i[p] || wait_n[p] || (held_n && owner_n == IW'(p))) begin
          err_n[p] = 1'b1;
        end else if (!held_n) begin
          held_n   = 1'b1;
          owner_n  = IW'(p);
          gnt_n[p] = 1'b1;
        end else begin
          line_n[ring_pos(head_n, cnt_n, NPROC)] = IW'(p);
          cnt_n     = cnt_n + CW'(1);
          wait_n[p] = 1'b1;
        end
      end else if (rel_i[p]) begin
        if (!held_n || owner_n != IW'(p)) begin
          err_n[p] = 1'b1;
        end else if (cnt_n != '0) begin
          owner_n         = line_n[head_n];
          wait_n[owner_n] = 1'b0;
          gnt_n[owner_n]  = 1'b1;
          head_n          = IW'(ring_pos(head_n, 1, NPROC));
          cnt_n           = cnt_n - CW'(1);
        end else begin
          held_n = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      owner_q <= '0;
      head_q  <= '0;
      cnt_q   <= '0;
      wait_q  <= '0;
      grant_o <= '0;
      err_o   <= '0;
      for (int k = 0; k < NPROC; k++) line_q[k] <= '0;
    end else begin
      held_q  <= held_n;
      owner_q <= owner_n;
      head_q  <= head_n;
      cnt_q   <= cnt_n;
      wait_q  <= wait_n;
      grant_o <= gnt_n;
      err_o   <= err_n;
      line_q  <= line_n;
    end
  end

  assign wait_o  = wait_q;
  assign held_o  = held_q;
  assign owner_o = owner_q;
  assign qcnt_o  = cnt_q;

endmodule

// File: rtl/qlk_counter.sv
module qlk_counter #(
  parameter int NPROC = 4,
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NPROC-1:0]            inc_i,
  output logic [NPROC-1:0]            vld_o,
  output logic [NPROC-1:0][CNT_W-1:0] val_o
);

  logic [CNT_W-1:0]            cnt_q, cnt_n;
  logic [NPROC-1:0][CNT_W-1:0] val_n;

  always_comb begin
    cnt_n = cnt_q;
    val_n = '0;
    for (int p = 0; p < NPROC; p++) begin
      if (inc_i[p]) begin
        val_n[p] = cnt_n;
        cnt_n    = cnt_n + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      vld_o <= '0;
      val_o <= '0;
    end else begin
      cnt_q <= cnt_n;
      vld_o <= inc_i;
      val_o <= val_n;
    end
  end

endmodule

// File: rtl/qlk_unit.sv
module qlk_unit
  import qlk_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NLOCK = 4,
  parameter int CNT_W = 16,
  localparam int LW = idx_bits(NLOCK),
  localparam int IW = idx_bits(NPROC),
  localparam int CW = $clog2(NPROC + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPROC-1:0]       req_valid,
  input  logic [2*NPROC-1:0]     req_op,
  input  logic [LW*NPROC-1:0]    req_lock,
  output logic [NPROC-1:0]       grant,
  output logic [LW*NPROC-1:0]    grant_lock,
  output logic [NPROC-1:0]       err,
  output logic [NPROC-1:0]       ret_valid,
  output logic [CNT_W*NPROC-1:0] ret_val
);

  logic [NLOCK-1:0][NPROC-1:0] acq, rel, fai;
  logic [NLOCK-1:0][NPROC-1:0] slot_gnt, slot_err, slot_wait;
  logic [NLOCK-1:0]            slot_held;
  logic [NLOCK-1:0][IW-1:0]    slot_owner;
  logic [NLOCK-1:0][CW-1:0]    slot_qcnt;
  logic [NLOCK-1:0][NPROC-1:0] cnt_vld;
  logic [NLOCK-1:0][NPROC-1:0][CNT_W-1:0] cnt_val;
  logic [NPROC-1:0]            busy;

  qlk_req_decode #(.NPROC(NPROC), .NLOCK(NLOCK), .LW(LW)) u_dec (
    .req_valid(req_valid),
    .req_op   (req_op),
    .req_lock (req_lock),
    .acq_o    (acq),
    .rel_o    (rel),
    .fai_o    (fai)
  );

  // A processor waiting on any lock may not post another acquire.
  always_comb begin
    busy = '0;
    for (int l = 0; l < NLOCK; l++) busy = busy | slot_wait[l];
  end

  for (genvar l = 0; l < NLOCK; l++) begin : g_lock
    qlk_lock_slot #(.NPROC(NPROC)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .acq_i  (acq[l]),
      .rel_i  (rel[l]),
      .busy_i (busy),
      .grant_o(slot_gnt[l]),
      .err_o  (slot_err[l]),
      .wait_o (slot_wait[l]),
      .held_o (slot_held[l]),
      .owner_o(slot_owner[l]),
      .qcnt_o (slot_qcnt[l])
    );

    qlk_counter #(.NPROC(NPROC), .CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc_i(fai[l]),
      .vld_o(cnt_vld[l]),
      .val_o(cnt_val[l])
    );
  end

  always_comb begin
    grant      = '0;
    grant_lock = '0;
    err        = '0;
    ret_valid  = '0;
    ret_val    = '0;
    for (int p = 0; p < NPROC; p++) begin
      for (int l = 0; l < NLOCK; l++) begin
        if (slot_gnt[l][p]) begin
          grant[p]                = 1'b1;
          grant_lock[LW*p +: LW]  = LW'(l);
        end
        if (slot_err[l][p]) err[p] = 1'b1;
        if (cnt_vld[l][p]) begin
          ret_valid[p]                 = 1'b1;
          ret_val[CNT_W*p +: CNT_W]    = cnt_val[l][p];
        end
      end
    end
  end

endmodule

// File: rtl/qlk_chk.sv
module qlk_chk
  import qlk_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NLOCK = 4,
  parameter int LW    = 2,
  parameter int IW    = 2,
  parameter int CW    = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NPROC-1:0]            req_valid,
  input logic [2*NPROC-1:0]          req_op,
  input logic [LW*NPROC-1:0]         req_lock,
  input logic [NPROC-1:0]            err,
  input logic [NPROC-1:0]            ret_valid,
  input logic [NLOCK-1:0][NPROC-1:0] slot_gnt,
  input logic [NLOCK-1:0][NPROC-1:0] slot_wait,
  input logic [NLOCK-1:0]            slot_held,
  input logic [NLOCK-1:0][IW-1:0]    slot_owner,
  input logic [NLOCK-1:0][CW-1:0]    slot_qcnt
);

  for (genvar l = 0; l < NLOCK; l++) begin : g_l
    p_one_grant_per_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_gnt[l]));

    p_no_free_with_waiters_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_held[l] && slot_qcnt[l] != '0) |=> slot_held[l]);

    p_line_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
      slot_qcnt[l] <= CW'(NPROC - 1));

    for (genvar p = 0; p < NPROC; p++) begin : g_p
      p_bad_release_flagged_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[p] && req_op[2*p +: 2] == OP_REL && req_lock[LW*p +: LW] == LW'(l)
         && !slot_wait[l][p] && (!slot_held[l] || slot_owner[l] != IW'(p)))
        |=> err[p]);

      p_fai_returns_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[p] && req_op[2*p +: 2] == OP_FAI && req_lock[LW*p +: LW] == LW'(l))
        |=> ret_valid[p]);
    end
  end

  for (genvar p = 0; p < NPROC; p++) begin : g_pp
    logic [NLOCK-1:0] col;
    always_comb for (int l = 0; l < NLOCK; l++) col[l] = slot_gnt[l][p];
    p_one_grant_per_proc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));
  end

endmodule

bind qlk_unit qlk_chk #(
  .NPROC(NPROC), .NLOCK(NLOCK), .LW(LW), .IW(IW), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_lock  (req_lock),
  .err       (err),
  .ret_valid (ret_valid),
  .slot_gnt  (slot_gnt),
  .slot_wait (slot_wait),
  .slot_held (slot_held),
  .slot_owner(slot_owner),
  .slot_qcnt (slot_qcnt)
);

// File: tb/tb_qlk_unit.sv
`timescale 1ns/1ps
module tb_qlk_unit;

  localparam int NPROC = 4;
  localparam int NLOCK = 4;
  localparam int CNT_W = 4;
  localparam int LW    = 2;

  localparam logic [1:0] ACQ = 2'd0;
  localparam logic [1:0] REL = 2'd1;
  localparam logic [1:0] FAI = 2'd2;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic [NPROC-1:0]       req_valid;
  logic [2*NPROC-1:0]     req_op;
  logic [LW*NPROC-1:0]    req_lock;
  logic [NPROC-1:0]       grant;
  logic [LW*NPROC-1:0]    grant_lock;
  logic [NPROC-1:0]       err;
  logic [NPROC-1:0]       ret_valid;
  logic [CNT_W*NPROC-1:0] ret_val;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  qlk_unit #(.NPROC(NPROC), .NLOCK(NLOCK), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_lock(req_lock), .grant(grant), .grant_lock(grant_lock), .err(err),
    .ret_valid(ret_valid), .ret_val(ret_val)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input int p, input logic [1:0] op, input int lk);
    req_valid[p]         = 1'b1;
    req_op[2*p +: 2]     = op;
    req_lock[LW*p +: LW] = LW'(lk);
  endtask

  // Apply the queued lanes at one edge; outputs are then read in the cycle after.
  task automatic step();
    @(posedge clk);
    #1;
    req_valid = '0;
  endtask

  function automatic logic [CNT_W-1:0] rv(input int p);
    return ret_val[CNT_W*p +: CNT_W];
  endfunction

  task automatic t_reset();
    chk("R1 grant after reset", 32'(grant), 0);
    chk("R1 err after reset", 32'(err), 0);
    chk("R1 ret_valid after reset", 32'(ret_valid), 0);
    put(0, FAI, 0); step();
    chk("R1 counter starts at zero", 32'(rv(0)), 0);
  endtask

  task automatic t_queue();
    put(1, ACQ, 0); step();
    chk("R2 free acquire grant", 32'(grant), 32'b0010);
    chk("R2 grant lock number", 32'(grant_lock[LW*1 +: LW]), 0);
    put(2, ACQ, 0); step();
    chk("R3 held acquire no grant", 32'(grant), 0);
    put(3, ACQ, 0); step();
    chk("R3 second waiter no grant", 32'(grant), 0);
    put(1, REL, 0); step();
    chk("R4 handoff to oldest waiter", 32'(grant), 32'b0100);
    chk("R12 single grant on handoff", $countones(grant), 1);
    put(2, REL, 0); step();
    chk("R4 next waiter in arrival order", 32'(grant), 32'b1000);
    put(3, REL, 0); step();
    chk("R6 release with empty line", 32'(grant) | 32'(err), 0);
    put(0, ACQ, 0); step();
    chk("R6 acquire after free granted", 32'(grant), 32'b0001);
  endtask

  task automatic t_errors();
    // P0 holds lock 0 here.
    put(2, REL, 0); step();
    chk("R7 non-holder release flagged", 32'(err), 32'b0100);
    chk("R7 non-holder release no grant", 32'(grant), 0);
    put(1, ACQ, 0); step();
    chk("R3 waiter queued", 32'(grant) | 32'(err), 0);
    put(1, ACQ, 2); step();
    chk("R8 acquire while waiting flagged", 32'(err), 32'b0010);
    chk("R8 acquire while waiting no grant", 32'(grant), 0);
    put(0, ACQ, 0); step();
    chk("R8 acquire by holder flagged", 32'(err), 32'b0001);
    put(0, REL, 0); step();
    chk("R7 holder kept lock, hands to waiter", 32'(grant), 32'b0010);
    put(2, ACQ, 2); step();
    chk("R8 dropped acquire left lock 2 free", 32'(grant), 32'b0100);
    put(2, REL, 2); put(1, REL, 0); step();
    chk("R6 both releases clean", 32'(grant) | 32'(err), 0);
  endtask

  task automatic t_simul();
    put(3, ACQ, 1); put(1, ACQ, 1); put(2, ACQ, 1); step();
    chk("R5 lowest index wins", 32'(grant), 32'b0010);
    put(1, REL, 1); step();
    chk("R5 next lowest served", 32'(grant), 32'b0100);
    put(2, REL, 1); step();
    chk("R5 highest served last", 32'(grant), 32'b1000);
    put(3, REL, 1); put(0, ACQ, 2); put(1, ACQ, 3); step();
    chk("R11 separate locks granted together", 32'(grant), 32'b0011);
    chk("R11 lock 2 number", 32'(grant_lock[LW*0 +: LW]), 2);
    chk("R11 lock 3 number", 32'(grant_lock[LW*1 +: LW]), 3);
    put(0, REL, 2); put(1, REL, 3); step();
    chk("R11 releases clean", 32'(grant) | 32'(err), 0);
  endtask

  task automatic t_fai();
    put(2, FAI, 1); step();
    chk("R9 first value", 32'(rv(2)), 0);
    chk("R9 ret_valid", 32'(ret_valid), 32'b0100);
    put(2, FAI, 1); step();
    chk("R9 advanced by one", 32'(rv(2)), 1);
    put(3, FAI, 1); put(0, FAI, 1); step();
    chk("R10 lower index first", 32'(rv(0)), 2);
    chk("R10 higher index next", 32'(rv(3)), 3);
    put(1, FAI, 2); step();
    chk("R11 other counter untouched", 32'(rv(1)), 0);
    for (int i = 4; i < 16; i++) begin
      put(1, FAI, 1); step();
      chk("R9 counting run", 32'(rv(1)), 32'(i));
    end
    put(1, FAI, 1); step();
    chk("R9 wrap to zero", 32'(rv(1)), 0);
  endtask

  initial begin
    req_valid = '0;
    req_op    = '0;
    req_lock  = '0;
    rst_n     = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_queue();
    t_errors();
    t_simul();
    t_fai();
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule